// File: doc/BRIEF.md
# Dual-Channel Converter Result Readout Port

This block is the digital output side of a two-channel sampling converter. A small sequencer inside it stands in for the conversion engine. A start strobe captures both channel samples. A cycle counter then runs two conversion slots, channel A first and channel B second. Each channel's result register is loaded only when that channel's slot ends. A read therefore always sees a complete word. While a conversion runs, a read returns the result of the previous conversion.

A host reads the results in one of two modes, chosen by `ser_mode`.
- **Parallel mode:** the host gets a 16-bit word that it enables with active-low chip-select and read strobes. A channel-select input picks the channel. A byte-swap input lets an 8-bit host fetch both halves from one byte lane.
- **Serial mode:** a frame request loads both results into a 32-bit frame. The frame is shifted out MSB first on one pin, and each bit advances on a falling edge of a host-supplied serial clock.

The block also gives the host a `busy` flag and a one-cycle end-of-conversion pulse for channel A.

Top module: `dual_result_port`

## Requirements
- R1: After reset, `busy`, `eoc` and `sdo` are 0, and a parallel read of either channel returns 16'h0000.
- R2: `conv_start` sampled while idle raises `busy` on the next cycle. `busy` stays high for exactly 2*CONV_CYC cycles. A `conv_start` while busy is ignored, and so are sample input changes after the start.
- R3: `eoc` is high for exactly one cycle, CONV_CYC cycles after the start edge, when channel A finishes.
- R4: Channel A's new result is readable from the cycle `eoc` is high, while `busy` is still high. Channel B's new result appears only when `busy` falls.
- R5: A read during a conversion returns the previous conversion's result for any channel not yet finished.
- R6: In parallel mode, `chan_sel`=1 drives channel A's result and `chan_sel`=0 drives channel B's result.
- R7: With `byte_swap`=0, result bits [7:0] appear on `bus_data[7:0]` and bits [15:8] on `bus_data[15:8]`. With `byte_swap`=1, result bits [7:0] appear on `bus_data[15:8]` and bits [15:8] on `bus_data[7:0]`.
- R8: `bus_oe` is 1 only when `cs_n`=0, `rd_n`=0 and `ser_mode`=0. Otherwise `bus_oe` is 0 and `bus_data` is 0; `bus_oe`=0 stands for high impedance.
- R9: In serial mode (`ser_mode`=1), `frame_req` loads a 32-bit frame that is sent MSB first. The frame is {A,B} when `chan_sel`=1 at the request and {B,A} when `chan_sel`=0. `frame_req` is ignored in parallel mode.
- R10: `sdo` shows frame bit 31 after the request and changes only on a detected falling edge of `sclk`. After the 32nd falling edge, `sdo` stays at 0 until the next frame request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| conv_start | input | 1 | Conversion start strobe |
| smp_a | input | 16 | Channel A sample value |
| smp_b | input | 16 | Channel B sample value |
| ser_mode | input | 1 | 0 = parallel, 1 = serial |
| cs_n | input | 1 | Parallel chip-select, active low |
| rd_n | input | 1 | Parallel read strobe, active low |
| chan_sel | input | 1 | 1 = channel A, 0 = channel B (word in parallel mode, first word in serial mode) |
| byte_swap | input | 1 | Exchange the two bytes on the parallel bus |
| frame_req | input | 1 | Serial frame request |
| sclk | input | 1 | Serial clock from the host, slower than `clk` |
| bus_data | output | 16 | Parallel data |
| bus_oe | output | 1 | Parallel bus drive enable |
| sdo | output | 1 | Serial data out |
| busy | output | 1 | Conversion in progress |
| eoc | output | 1 | Channel A end-of-conversion pulse |

## Verification
The assertions check on every cycle that:
- a start from idle raises `busy`;
- `eoc` lasts a single cycle and comes only while `busy` is high;
- `busy` falls only at the end of channel B's slot;
- channel A's result register changes only with `eoc`;
- the serial output holds between falling edges of `sclk`, and the frame ends after 32 bits.

Only the bench scenarios show the data-dependent behaviour: byte placement under swap, channel selection, the serial bit order for both channel orders, and the previous-result values seen during a conversion.

// File: rtl/drp_pkg.sv
package drp_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_CONV_A = 2'd1,
    SEQ_CONV_B = 2'd2
  } seq_state_e;
endpackage

// File: rtl/drp_conv_seq.sv
module drp_conv_seq
  import drp_pkg::*;
#(
  parameter int RES_W    = 16,
  parameter int CONV_CYC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_start,
  input  logic [RES_W-1:0] smp_a,
  input  logic [RES_W-1:0] smp_b,
  output logic [RES_W-1:0] res_a,
  output logic [RES_W-1:0] res_b,
  output logic             busy,
  output logic             eoc
);
  localparam int CNT_W = (CONV_CYC > 2) ? $clog2(CONV_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CONV_CYC - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [RES_W-1:0] hold_a_q, hold_b_q;
  logic             start_ok, a_done, b_done;

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    start_ok = 1'b0;
    a_done   = 1'b0;
    b_done   = 1'b0;
    case (state_q)
      SEQ_IDLE: begin
        if (conv_start) begin
          start_ok = 1'b1;
          state_d  = SEQ_CONV_A;
          cnt_d    = '0;
        end
      end
      SEQ_CONV_A: begin
        if (cnt_q == CNT_LAST) begin
          a_done  = 1'b1;
          state_d = SEQ_CONV_B;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      SEQ_CONV_B: begin
        if (cnt_q == CNT_LAST) begin
          b_done  = 1'b1;
          state_d = SEQ_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      eoc     <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      eoc     <= a_done;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_a_q <= '0;
      hold_b_q <= '0;
    end else if (start_ok) begin
      hold_a_q <= smp_a;
      hold_b_q <= smp_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_a <= '0;
    end else if (a_done) begin
      res_a <= hold_a_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_b <= '0;
    end else if (b_done) begin
      res_b <= hold_b_q;
    end
  end

  assign busy = (state_q != SEQ_IDLE);

  // R2: a start from idle raises busy on the next cycle
  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_IDLE && conv_start) |=> busy);

  // R2: busy falls only at the end of channel B's slot
  a_r2_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(state_q == SEQ_CONV_B));

  // R3: end-of-conversion is a single-cycle pulse
  a_r3_eoc_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |=> !eoc);

  // R4: channel A completes while channel B is still converting
  a_r4_eoc_busy: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |-> (busy && state_q == SEQ_CONV_B));
endmodule

// File: rtl/drp_par_mux.sv
module drp_par_mux #(
  parameter int RES_W = 16
) (
  input  logic             ser_mode,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             chan_sel,
  input  logic             byte_swap,
  input  logic [RES_W-1:0] res_a,
  input  logic [RES_W-1:0] res_b,
  output logic [RES_W-1:0] bus_data,
  output logic             bus_oe
);
  localparam int HALF = RES_W / 2;

  logic [RES_W-1:0] word;
  logic [RES_W-1:0] lane;

  always_comb begin
    word   = chan_sel ? res_a : res_b;
    lane   = byte_swap ? {word[HALF-1:0], word[RES_W-1:HALF]} : word;
    bus_oe = !ser_mode && !cs_n && !rd_n;
    bus_data = bus_oe ? lane : '0;
  end
endmodule

// File: rtl/drp_ser_shift.sv
module drp_ser_shift #(
  parameter int RES_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_mode,
  input  logic             frame_req,
  input  logic             chan_sel,
  input  logic             sclk,
  input  logic [RES_W-1:0] res_a,
  input  logic [RES_W-1:0] res_b,
  output logic             sdo
);
  localparam int FRM_W = 2 * RES_W;
  localparam int BC_W  = $clog2(FRM_W);
  localparam logic [BC_W-1:0] BC_LAST = BC_W'(FRM_W - 1);

  logic             sclk_q;
  logic             active_q, active_d;
  logic [FRM_W-1:0] shreg_q, shreg_d;
  logic [BC_W-1:0]  bcnt_q, bcnt_d;
  logic             sclk_fall, load, shift_en;

  always_comb begin
    sclk_fall = sclk_q && !sclk;
    load      = ser_mode && frame_req && !active_q;
    shift_en  = active_q && sclk_fall;
    active_d  = active_q;
    shreg_d   = shreg_q;
    bcnt_d    = bcnt_q;
    if (load) begin
      active_d = 1'b1;
      shreg_d  = chan_sel ? {res_a, res_b} : {res_b, res_a};
      bcnt_d   = '0;
    end else if (shift_en) begin
      if (bcnt_q == BC_LAST) begin
        active_d = 1'b0;
        shreg_d  = '0;
      end else begin
        shreg_d = {shreg_q[FRM_W-2:0], 1'b0};
        bcnt_d  = bcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q   <= 1'b0;
      active_q <= 1'b0;
      shreg_q  <= '0;
      bcnt_q   <= '0;
    end else begin
      sclk_q   <= sclk;
      active_q <= active_d;
      if (load || shift_en) begin
        shreg_q <= shreg_d;
        bcnt_q  <= bcnt_d;
      end
    end
  end

  assign sdo = active_q && shreg_q[FRM_W-1];

  // R10: between falling edges of the serial clock the output holds
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !sclk_fall) |=> $stable(sdo));

  // R10: the frame ends after the last bit's falling edge
  a_r10_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && sclk_fall && bcnt_q == BC_LAST) |=> !active_q);

  // R9: no frame starts in parallel mode
  a_r9_par_no_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && !ser_mode) |=> !active_q);
endmodule

// File: rtl/dual_result_port.sv
module dual_result_port #(
  parameter int RES_W    = 16,
  parameter int CONV_CYC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_start,
  input  logic [RES_W-1:0] smp_a,
  input  logic [RES_W-1:0] smp_b,
  input  logic             ser_mode,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             chan_sel,
  input  logic             byte_swap,
  input  logic             frame_req,
  input  logic             sclk,
  output logic [RES_W-1:0] bus_data,
  output logic             bus_oe,
  output logic             sdo,
  output logic             busy,
  output logic             eoc
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [RES_W-1:0] res_a, res_b;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  drp_conv_seq #(.RES_W(RES_W), .CONV_CYC(CONV_CYC)) u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .conv_start (conv_start),
    .smp_a      (smp_a),
    .smp_b      (smp_b),
    .res_a      (res_a),
    .res_b      (res_b),
    .busy       (busy),
    .eoc        (eoc)
  );

  drp_par_mux #(.RES_W(RES_W)) u_par (
    .ser_mode  (ser_mode),
    .cs_n      (cs_n),
    .rd_n      (rd_n),
    .chan_sel  (chan_sel),
    .byte_swap (byte_swap),
    .res_a     (res_a),
    .res_b     (res_b),
    .bus_data  (bus_data),
    .bus_oe    (bus_oe)
  );

  drp_ser_shift #(.RES_W(RES_W)) u_ser (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .ser_mode  (ser_mode),
    .frame_req (frame_req),
    .chan_sel  (chan_sel),
    .sclk      (sclk),
    .res_a     (res_a),
    .res_b     (res_b),
    .sdo       (sdo)
  );

  // R4/R5: channel A's result only changes together with its end-of-conversion
  a_r5_res_a_only_at_eoc: assert property (@(posedge clk) disable iff (!rst_int_n)
    !eoc |-> $stable(res_a));

  // R5: channel B's result only changes as busy falls
  a_r5_res_b_only_at_end: assert property (@(posedge clk) disable iff (!rst_int_n)
    !$fell(busy) |-> $stable(res_b));
endmodule

// File: tb/test_dual_result_port.sv
module test_dual_result_port;
  localparam int RES_W = 16;
  localparam int CC    = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             conv_start = 1'b0;
  logic [RES_W-1:0] smp_a = '0, smp_b = '0;
  logic             ser_mode = 1'b0, cs_n = 1'b1, rd_n = 1'b1;
  logic             chan_sel = 1'b1, byte_swap = 1'b0;
  logic             frame_req = 1'b0, sclk = 1'b0;
  logic [RES_W-1:0] bus_data;
  logic             bus_oe, sdo, busy, eoc;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  dual_result_port #(.RES_W(RES_W), .CONV_CYC(CC)) i_dual_result_port (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .smp_a(smp_a), .smp_b(smp_b),
    .ser_mode(ser_mode), .cs_n(cs_n), .rd_n(rd_n), .chan_sel(chan_sel),
    .byte_swap(byte_swap), .frame_req(frame_req), .sclk(sclk),
    .bus_data(bus_data), .bus_oe(bus_oe), .sdo(sdo), .busy(busy), .eoc(eoc)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected<50000", cyc);
      finish_run();
    end
  end

  // Read one channel on the parallel bus (combinational path), no swap
  task automatic par_read(input logic sel, output logic [15:0] val);
    chan_sel = sel; byte_swap = 1'b0; cs_n = 1'b0; rd_n = 1'b0;
    #1 val = bus_data;
  endtask

  // {req[3:0], cs_n, rd_n, ser_mode, chan_sel, byte_swap, exp_oe, exp_data[15:0]}
  localparam logic [25:0] VEC [8] = '{
    {4'd6, 5'b00010, 1'b1, 16'h12C4},
    {4'd7, 5'b00011, 1'b1, 16'hC412},
    {4'd6, 5'b00000, 1'b1, 16'h7E09},
    {4'd7, 5'b00001, 1'b1, 16'h097E},
    {4'd8, 5'b10010, 1'b0, 16'h0000},
    {4'd8, 5'b01010, 1'b0, 16'h0000},
    {4'd8, 5'b00100, 1'b0, 16'h0000},
    {4'd8, 5'b11001, 1'b0, 16'h0000}
  };

  task automatic serial_frame(input logic sel, input logic [31:0] exp, input string tag);
    @(negedge clk);
    ser_mode = 1'b1; chan_sel = sel; frame_req = 1'b1;
    @(negedge clk);
    frame_req = 1'b0;
    chan_sel = ~sel;  // order is fixed at the request
    for (int i = 0; i < 32; i++) begin
      chk($sformatf("%s bit %0d", tag, 31 - i), {31'd0, sdo}, {31'd0, exp[31-i]});
      sclk = 1'b1;
      @(negedge clk); @(negedge clk);
      chk($sformatf("R10 hold while sclk high bit %0d", 31 - i), {31'd0, sdo}, {31'd0, exp[31-i]});
      sclk = 1'b0;
      @(negedge clk); @(negedge clk);
    end
    chk("R10 idle after 32nd bit", {31'd0, sdo}, 32'd0);
    for (int k = 0; k < 3; k++) begin
      sclk = 1'b1; @(negedge clk); @(negedge clk);
      sclk = 1'b0; @(negedge clk); @(negedge clk);
    end
    chk("R10 stays idle with extra sclk edges", {31'd0, sdo}, 32'd0);
  endtask

  initial begin
    logic [15:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 eoc", {31'd0, eoc}, 32'd0);
    chk("R1 sdo", {31'd0, sdo}, 32'd0);
    par_read(1'b1, rd); chk("R1 read A", {16'd0, rd}, 32'h0);
    par_read(1'b0, rd); chk("R1 read B", {16'd0, rd}, 32'h0);

    // Conversion with prev A=B=0, new A=12C4, B=7E09
    smp_a = 16'h12C4; smp_b = 16'h7E09; conv_start = 1'b1;
    @(negedge clk);  // start edge k has passed
    conv_start = 1'b0;
    for (int j = 0; j <= 2 * CC + 1; j++) begin
      if (j > 0) @(negedge clk);
      if (j == 3) begin
        // R2: second start and new samples while busy are ignored
        conv_start = 1'b1; smp_a = 16'hFFFF; smp_b = 16'hEEEE;
      end else begin
        conv_start = 1'b0;
      end
      chk($sformatf("R2 busy j=%0d", j), {31'd0, busy}, {31'd0, (j < 2 * CC)});
      chk($sformatf("R3 eoc j=%0d", j), {31'd0, eoc}, {31'd0, (j == CC)});
      par_read(1'b1, rd);
      chk($sformatf("R4/R5 A during conv j=%0d", j), {16'd0, rd}, (j < CC) ? 32'h0 : 32'h12C4);
      par_read(1'b0, rd);
      chk($sformatf("R5 B during conv j=%0d", j), {16'd0, rd}, (j < 2 * CC) ? 32'h0 : 32'h7E09);
    end
    @(negedge clk);
    conv_start = 1'b0;
    repeat (2 * CC + 4) @(negedge clk);
    chk("R2 ignored start left idle", {31'd0, busy}, 32'd0);

    // R6/R7/R8: parallel vectors
    foreach (VEC[n]) begin
      {cs_n, rd_n, ser_mode, chan_sel, byte_swap} = VEC[n][21:17];
      #1;
      chk($sformatf("R%0d vec %0d oe", VEC[n][25:22], n), {31'd0, bus_oe}, {31'd0, VEC[n][16]});
      chk($sformatf("R%0d vec %0d data", VEC[n][25:22], n), {16'd0, bus_data}, {16'd0, VEC[n][15:0]});
      @(negedge clk);
    end
    cs_n = 1'b1; rd_n = 1'b1;

    // R9: frame request in parallel mode is ignored
    ser_mode = 1'b0; frame_req = 1'b1;
    @(negedge clk); frame_req = 1'b0;
    sclk = 1'b1; @(negedge clk); @(negedge clk); sclk = 1'b0; @(negedge clk); @(negedge clk);
    chk("R9 frame_req ignored in parallel mode", {31'd0, sdo}, 32'd0);

    // R9/R10: serial frames in both channel orders
    serial_frame(1'b1, {16'h12C4, 16'h7E09}, "R9 A-first");
    serial_frame(1'b0, {16'h7E09, 16'h12C4}, "R9 B-first");

    done = 1'b1;
    finish_run();
  end
endmodule